// File: doc/BRIEF.md
# Ring Buffer Audio DMA Address Engine

This block produces the memory addresses for an audio stream that moves between a circular buffer in system memory and a local sample FIFO. Software programs the buffer bounds, a starting pointer, an interrupt period counted in bursts and a FIFO request threshold. Once the run bit is set, the engine watches the FIFO level. When enough data is present, it raises a request for one 8-byte burst toward the memory port. After each burst is acknowledged, the pointer steps forward, and it returns to the buffer base after the last burst slot.

The memory bus is reduced to a request and acknowledge pair, and the audio serializer is reduced to a FIFO level input. A build-time parameter picks the stream direction. In capture, requests follow the stored level. In playback, requests follow the free space. Each time the programmed number of bursts completes, a sticky status bit is set. The interrupt line is the OR of the status bits that are enabled. A status bit is released by a clear mask that software writes and then withdraws. A second status word can show the pointer, the period counter or the FIFO level.

Top module: `ring_dma_engine`

## Requirements
- R1: After reset, `mem_req` and `irq` are low, all writable registers read as zero, and the second status word (selector 0) reads 0.
- R2: In capture mode, with threshold code T (THRESH register, word 6, bits [7:0]), a request is raised only once `fifo_level` is at least (T+1)*8 bytes. Code 0 means 8 bytes. At most one burst is granted per request: after an acknowledge, `mem_req` is low for the following cycle.
- R3: `mem_addr` steps by 8 after each acknowledged burst. After the burst whose address equals the LAST register (word 3), the next address is the BASE register (word 2).
- R4: When the PERIOD register (word 5) holds N > 0, status bit 0 (STAT1, word 7) is set on every Nth acknowledged burst, and the burst counter then restarts from 0.
- R5: `irq` is high exactly when some status bit is set and its enable (CTRL0, word 0, bits [15:8]) is set. With enable bit 8 clear, status bit 0 is still recorded but `irq` stays low.
- R6: Status bits stay set until released. Writing a nonzero mask to CTRL1 (word 1) bits [7:0] clears nothing. A later CTRL1 write with bits [7:0] zero clears the status bits that were in the mask.
- R7: Clearing the run bit (CTRL0 bit 0) drops `mem_req` within one cycle and holds the pointer. Setting it again resumes requests at the same pointer.
- R8: A write to INIT (word 4) arms a reload. The next rising edge of the run bit loads the pointer with INIT and zeroes the burst counter. A run bit rise with no INIT write since the last reload does not move the pointer.
- R9: The second status word (word 8) shows what CTRL1 bits [17:16] select: 0 gives the burst counter, 1 gives the pointer, 2 gives the FIFO level, 3 gives zero.
- R10: The lowest three bits written to BASE, LAST and INIT are ignored and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| fifo_level | input | 9 | Bytes currently held in the local FIFO |
| mem_req | output | 1 | Burst request toward memory |
| mem_addr | output | 32 | Address of the requested burst |
| mem_ack | input | 1 | One-cycle burst completion, valid only with mem_req |
| irq | output | 1 | Enabled status OR |

## Verification
The bench runs a four-slot ring with a two-burst period through more than one lap. If the wrap compared against the end of the buffer rather than the last burst slot, the bench would see an address past the ring. If the period counter did not restart, the status bit would appear at the wrong bursts. The bench pauses and resumes in the middle of a pending request. A design that reloaded the pointer on every enable would restart at the base instead of the held address. The bench also checks the threshold at codes 0 and 1, one byte below and exactly at the limit, where an off-by-one in the bursts-minus-one coding shows. It checks that the clear mask does nothing until it is withdrawn, so a design that cleared on the first write would report the bit gone too early.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
  localparam int unsigned ADDR_W      = 32;
  localparam int unsigned BURST_BYTES = 8;
  localparam int unsigned BURST_SH    = $clog2(BURST_BYTES);
  localparam int unsigned PER_W       = 16;
  localparam int unsigned NSRC        = 8;
  localparam int unsigned THR_W       = 8;

  typedef enum logic [3:0] {
    RA_CTRL0  = 4'd0,
    RA_CTRL1  = 4'd1,
    RA_BASE   = 4'd2,
    RA_LAST   = 4'd3,
    RA_INIT   = 4'd4,
    RA_PERIOD = 4'd5,
    RA_THRESH = 4'd6,
    RA_STAT1  = 4'd7,
    RA_STAT2  = 4'd8
  } reg_idx_e;

  typedef enum logic [1:0] {
    S2_COUNT   = 2'd0,
    S2_POINTER = 2'd1,
    S2_LEVEL   = 2'd2,
    S2_NONE    = 2'd3
  } stat2_sel_e;

  typedef enum logic {
    RQ_IDLE = 1'b0,
    RQ_WAIT = 1'b1
  } rq_state_e;
endpackage

// File: rtl/ring_dma_regs.sv
module ring_dma_regs
  import ring_dma_pkg::*;
#(
  parameter int unsigned LVL_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [3:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [NSRC-1:0]   set_evt,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [PER_W-1:0]  cnt,
  input  logic [LVL_W-1:0]  level,
  output logic              run,
  output logic              load,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] last,
  output logic [ADDR_W-1:0] init,
  output logic [PER_W-1:0]  period,
  output logic [THR_W-1:0]  thr,
  output logic              irq
);
  logic              run_q, run_n, run_d_q;
  logic              pend_q, pend_n;
  logic [NSRC-1:0]   en_q, en_n;
  logic [NSRC-1:0]   clr_q, clr_n;
  logic [1:0]        sel_q, sel_n;
  logic [ADDR_W-1:0] base_q, base_n, last_q, last_n, init_q, init_n;
  logic [PER_W-1:0]  per_q, per_n;
  logic [THR_W-1:0]  thr_q, thr_n;
  logic [NSRC-1:0]   sts_q, sts_n;
  logic [NSRC-1:0]   release_mask;
  logic              release_wr;
  logic [ADDR_W-1:0] aligned_wd;
  logic              unused_wd;

  assign unused_wd  = ^wdata;
  assign aligned_wd = {wdata[ADDR_W-1:BURST_SH], {BURST_SH{1'b0}}};
  assign release_wr = we && (addr == RA_CTRL1) && (wdata[NSRC-1:0] == '0);
  assign release_mask = release_wr ? clr_q : '0;
  assign load = run_q & ~run_d_q & pend_q;

  always_comb begin
    run_n  = run_q;  en_n   = en_q;   clr_n  = clr_q;  sel_n = sel_q;
    base_n = base_q; last_n = last_q; init_n = init_q;
    per_n  = per_q;  thr_n  = thr_q;
    pend_n = load ? 1'b0 : pend_q;
    if (we) begin
      case (addr)
        RA_CTRL0: begin
          run_n = wdata[0];
          en_n  = wdata[8 +: NSRC];
        end
        RA_CTRL1: begin
          clr_n = wdata[NSRC-1:0];
          sel_n = wdata[17:16];
        end
        RA_BASE:   base_n = aligned_wd;
        RA_LAST:   last_n = aligned_wd;
        RA_INIT: begin
          init_n = aligned_wd;
          pend_n = 1'b1;
        end
        RA_PERIOD: per_n = wdata[PER_W-1:0];
        RA_THRESH: thr_n = wdata[THR_W-1:0];
        default: ;
      endcase
    end
    sts_n = (sts_q & ~release_mask) | set_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; run_d_q <= 1'b0; pend_q <= 1'b1;
      en_q <= '0; clr_q <= '0; sel_q <= '0;
      base_q <= '0; last_q <= '0; init_q <= '0;
      per_q <= '0; thr_q <= '0; sts_q <= '0;
    end else begin
      run_q <= run_n; run_d_q <= run_q; pend_q <= pend_n;
      en_q <= en_n; clr_q <= clr_n; sel_q <= sel_n;
      base_q <= base_n; last_q <= last_n; init_q <= init_n;
      per_q <= per_n; thr_q <= thr_n; sts_q <= sts_n;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_CTRL0:  rdata = {{(32-8-NSRC){1'b0}}, en_q, 7'b0, run_q};
      RA_CTRL1:  rdata = {14'b0, sel_q, {(16-NSRC){1'b0}}, clr_q};
      RA_BASE:   rdata = base_q;
      RA_LAST:   rdata = last_q;
      RA_INIT:   rdata = init_q;
      RA_PERIOD: rdata = {{(32-PER_W){1'b0}}, per_q};
      RA_THRESH: rdata = {{(32-THR_W){1'b0}}, thr_q};
      RA_STAT1:  rdata = {{(32-NSRC){1'b0}}, sts_q};
      RA_STAT2: begin
        case (stat2_sel_e'(sel_q))
          S2_COUNT:   rdata = {{(32-PER_W){1'b0}}, cnt};
          S2_POINTER: rdata = ptr;
          S2_LEVEL:   rdata = {{(32-LVL_W){1'b0}}, level};
          default:    rdata = '0;
        endcase
      end
      default: rdata = '0;
    endcase
  end

  assign run    = run_q;
  assign base   = base_q;
  assign last   = last_q;
  assign init   = init_q;
  assign period = per_q;
  assign thr    = thr_q;
  assign irq    = |(sts_q & en_q);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[0] && !release_wr) |=> sts_q[0]);
  assert_release_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (release_wr && clr_q[0] && !set_evt[0]) |=> !sts_q[0]);
endmodule

// File: rtl/ring_dma_ptr.sv
module ring_dma_ptr
  import ring_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] last,
  input  logic [ADDR_W-1:0] init,
  input  logic [PER_W-1:0]  period,
  output logic [ADDR_W-1:0] ptr,
  output logic [PER_W-1:0]  cnt,
  output logic              evt
);
  logic [ADDR_W-1:0] ptr_q, ptr_n;
  logic [PER_W-1:0]  cnt_q, cnt_n;
  logic [PER_W:0]    cnt_inc;
  logic              hit;

  assign cnt_inc = {1'b0, cnt_q} + {{PER_W{1'b0}}, 1'b1};
  assign hit     = (period != '0) && (cnt_inc >= {1'b0, period});
  assign evt     = adv && !load && hit;

  always_comb begin
    ptr_n = ptr_q;
    cnt_n = cnt_q;
    if (load) begin
      ptr_n = init;
      cnt_n = '0;
    end else if (adv) begin
      ptr_n = (ptr_q == last) ? base : ptr_q + ADDR_W'(BURST_BYTES);
      cnt_n = hit ? '0 : cnt_inc[PER_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      ptr_q <= ptr_n;
      cnt_q <= cnt_n;
    end
  end

  assign ptr = ptr_q;
  assign cnt = cnt_q;

  assert_wrap_to_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && ptr_q == last) |=> (ptr_q == $past(base)));
  assert_step_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && ptr_q != last) |=> (ptr_q == $past(ptr_q) + ADDR_W'(BURST_BYTES)));
  assert_period_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (cnt_q == '0));
endmodule

// File: rtl/ring_dma_req.sv
module ring_dma_req
  import ring_dma_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 256,
  parameter bit          CAPTURE    = 1'b1,
  parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [THR_W-1:0] thr,
  input  logic [LVL_W-1:0] level,
  input  logic             ack,
  output logic             req,
  output logic             adv
);
  localparam int unsigned CW = 16;

  rq_state_e       st_q, st_n;
  logic [CW-1:0]   thr_bytes;
  logic [CW-1:0]   avail;
  logic            want;

  assign thr_bytes = (CW'(thr) + CW'(1)) << BURST_SH;

  generate
    if (CAPTURE) begin : g_capture
      assign avail = CW'(level);
    end else begin : g_playback
      assign avail = CW'(FIFO_DEPTH) - CW'(level);
    end
  endgenerate

  assign want = (avail >= thr_bytes);
  assign adv  = (st_q == RQ_WAIT) && ack && run;

  always_comb begin
    st_n = st_q;
    case (st_q)
      RQ_IDLE: if (run && want) st_n = RQ_WAIT;
      RQ_WAIT: if (!run || ack) st_n = RQ_IDLE;
      default: st_n = RQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RQ_IDLE;
    else        st_q <= st_n;
  end

  assign req = (st_q == RQ_WAIT);

  assert_stop_drops_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !req);
  assert_one_burst_per_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> !req);
endmodule

// File: rtl/ring_dma_engine.sv
module ring_dma_engine
  import ring_dma_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 256,
  parameter bit          CAPTURE    = 1'b1,
  parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [LVL_W-1:0]  fifo_level,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  output logic              irq
);
  logic              run, load, adv, evt;
  logic [ADDR_W-1:0] base, last, init, ptr;
  logic [PER_W-1:0]  period, cnt;
  logic [THR_W-1:0]  thr;
  logic [NSRC-1:0]   set_evt;

  assign set_evt = {{(NSRC-1){1'b0}}, evt};

  ring_dma_regs #(.LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .set_evt(set_evt), .ptr(ptr), .cnt(cnt), .level(fifo_level),
    .run(run), .load(load), .base(base), .last(last), .init(init),
    .period(period), .thr(thr), .irq(irq)
  );

  ring_dma_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(adv), .base(base), .last(last),
    .init(init), .period(period), .ptr(ptr), .cnt(cnt), .evt(evt)
  );

  ring_dma_req #(.FIFO_DEPTH(FIFO_DEPTH), .CAPTURE(CAPTURE), .LVL_W(LVL_W)) u_req (
    .clk(clk), .rst_n(rst_n), .run(run), .thr(thr), .level(fifo_level),
    .ack(mem_ack), .req(mem_req), .adv(adv)
  );

  assign mem_addr = ptr;
endmodule

// File: tb/ring_dma_engine_tb.sv
module ring_dma_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [8:0]  fifo_level;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  ring_dma_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_level(fifo_level),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .irq(irq)
  );

  // {expected status bit 0 after burst, expected burst address}
  localparam logic [32:0] WALK [6] = '{
    {1'b0, 32'h100}, {1'b1, 32'h108}, {1'b0, 32'h110},
    {1'b1, 32'h118}, {1'b0, 32'h100}, {1'b1, 32'h108}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FIAL_MARK", "");
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic burst(input string tag, input logic [31:0] exp_addr);
    int waited = 0;
    while (!mem_req && waited < 50) begin
      @(negedge clk);
      waited++;
    end
    chk({tag, " request seen"}, 32'(mem_req), 32'd1);
    chk({tag, " burst address"}, mem_addr, exp_addr);
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
  endtask

  task automatic release_status(input string tag);
    logic [31:0] v;
    wr(4'd1, 32'h0001_0001);
    rd(4'd7, v);
    chk({tag, " R6 mask alone keeps status"}, v & 32'h1, 32'h1);
    wr(4'd1, 32'h0001_0000);
    rd(4'd7, v);
    chk({tag, " R6 mask withdrawn clears status"}, v & 32'h1, 32'h0);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    fifo_level = '0; mem_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 mem_req in reset", 32'(mem_req), 32'd0);
    chk("R1 irq in reset", 32'(irq), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'd2, v); chk("R1 base after reset", v, 32'h0);
    rd(4'd0, v); chk("R1 ctrl0 after reset", v, 32'h0);
    rd(4'd8, v); chk("R1 status2 after reset", v, 32'h0);

    // R10: low address bits ignored
    wr(4'd2, 32'h0000_0107);
    rd(4'd2, v); chk("R10 base low bits", v, 32'h100);
    wr(4'd3, 32'h0000_011F);
    rd(4'd3, v); chk("R10 last low bits", v, 32'h118);
    wr(4'd4, 32'h0000_0103);
    rd(4'd4, v); chk("R10 init low bits", v, 32'h100);
    wr(4'd5, 32'd2);
    wr(4'd6, 32'd0);
    wr(4'd1, 32'h0001_0000);
    wr(4'd0, 32'h0000_0100);

    // R2: threshold code 0 is one burst (8 bytes)
    fifo_level = 9'd7;
    wr(4'd0, 32'h0000_0101);
    repeat (4) @(negedge clk);
    chk("R2 code0 level7 no request", 32'(mem_req), 32'd0);
    fifo_level = 9'd8;
    repeat (2) @(negedge clk);
    chk("R2 code0 level8 request", 32'(mem_req), 32'd1);

    // R3/R4/R5/R6: walk the ring table
    for (int i = 0; i < 6; i++) begin
      burst("R3 walk", WALK[i][31:0]);
      rd(4'd7, v);
      chk("R4 period status after burst", v & 32'h1, 32'(WALK[i][32]));
      chk("R5 irq follows enabled status", 32'(irq), 32'(WALK[i][32]));
      if (WALK[i][32]) release_status("walk");
    end

    // R7: pause with a pending request, then resume
    repeat (2) @(negedge clk);
    chk("R7 pending request before pause", 32'(mem_req), 32'd1);
    chk("R7 pending address", mem_addr, 32'h110);
    wr(4'd0, 32'h0000_0100);
    repeat (2) @(negedge clk);
    chk("R7 request dropped on pause", 32'(mem_req), 32'd0);
    repeat (5) @(negedge clk);
    rd(4'd8, v); chk("R7 pointer held while paused", v, 32'h110);
    wr(4'd0, 32'h0000_0101);
    burst("R7 R8 resume without reload", 32'h110);

    // R2: threshold code 1 needs 16 bytes
    wr(4'd0, 32'h0000_0100);
    wr(4'd6, 32'd1);
    fifo_level = 9'd15;
    wr(4'd0, 32'h0000_0101);
    repeat (4) @(negedge clk);
    chk("R2 code1 level15 no request", 32'(mem_req), 32'd0);
    fifo_level = 9'd16;
    repeat (2) @(negedge clk);
    chk("R2 code1 level16 request", 32'(mem_req), 32'd1);
    burst("R3 last slot", 32'h118);
    rd(4'd7, v); chk("R4 second burst of period", v & 32'h1, 32'h1);
    release_status("code1");

    // R5: status recorded but irq masked
    wr(4'd0, 32'h0000_0001);
    burst("R3 wrap to base", 32'h100);
    burst("R3 step after wrap", 32'h108);
    rd(4'd7, v); chk("R5 status with enable off", v & 32'h1, 32'h1);
    chk("R5 irq masked", 32'(irq), 32'd0);
    release_status("masked");

    // R8: reload from INIT on next run rise
    wr(4'd0, 32'h0000_0100);
    wr(4'd4, 32'h0000_0108);
    wr(4'd0, 32'h0000_0101);
    burst("R8 reload from init", 32'h108);
    wr(4'd0, 32'h0000_0100);
    wr(4'd1, 32'h0000_0000);
    rd(4'd8, v); chk("R8 R9 counter restarted then one burst", v, 32'd1);

    // R9: other selector values
    wr(4'd1, 32'h0002_0000);
    rd(4'd8, v); chk("R9 level view", v, 32'd16);
    wr(4'd1, 32'h0003_0000);
    rd(4'd8, v); chk("R9 empty view", v, 32'd0);
    wr(4'd1, 32'h0001_0000);
    rd(4'd8, v); chk("R9 pointer view", v, 32'h110);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule